// File: doc/BRIEF.md
# Functional Test Program Sequencer

This block runs functional tests on a small accumulator processor that sits beside it. It drives the processor's instruction and data-input ports with short generated programs and compares the processor's output port against values from its own model of the ten-instruction set. No program memory is involved. Every test step uses the same four-instruction template: load R from the input port, load A from the input port, execute the instruction under test, then copy A to the output port. A fifth cycle compares the result.

Two test modes share this template. The adder scan repeats it with ADD as the operation for every pairing of two 4-bit operands. The decode-conformity test keeps the operands fixed and puts each instruction code from 1 to 10 in the operation slot, so a wrongly decoded instruction shows up as a wrong value on the output port. A start pulse launches a run. The run stops at the first mismatch, and the block then reports a fail flag and the index of the step that failed.

Top module: `func_test_seq`

## Requirements
- R1: After reset, `busy`, `done`, `fail` and `instr_valid` are all low.
- R2: A `start` pulse while idle begins a run in the mode given by `mode_sel` (0 = adder scan, 1 = decode test) and clears `done` and `fail`. While a run is in progress, `start` and `mode_sel` have no effect.
- R3: Each step issues four instructions on four consecutive cycles with `instr_valid` high, in the order code 5, code 1, operation, code 4. One cycle with `instr_valid` low follows. A step therefore takes five cycles.
- R4: In the adder scan the operation is code 7. `in_data` carries R during code 5 and A during code 1, and carries 0 during the last two instructions. Step k (k = 16*A + R) runs for k = 0 up to 255 in ascending order.
- R5: In the decode test, step D runs for D = 1 up to 10 in ascending order and uses D as the operation code. `in_data` is 0x33 during code 5, 0x0F during code 1, and 0x5A during the last two instructions.
- R6: The expected output comes from a model with these codes: 1 and 6 set A from input, 2 copies A to R, 3 sends R to the output, 4 sends A to the output, 5 sets R from input, 7 adds R to A (modulo 256), 8 ORs R into A, 9 ANDs R into A, 10 inverts A. Any other code changes nothing.
- R7: In the cycle with `instr_valid` low after code 4, `proc_out` is compared with the model's output. On a mismatch the run stops: `fail` and `done` go high at the next edge, `fail_index` holds the step index (k for the adder scan, D for the decode test), and no further instructions are issued.
- R8: If every step matches, `done` goes high with `fail` low after the last step. `done`, `fail` and `fail_index` then hold their values until the next `start`.
- R9: A new run after a failed run clears `fail` and reports its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a run when idle |
| mode_sel | input | 1 | 0 = adder scan, 1 = decode test; sampled with start |
| instr_valid | output | 1 | An instruction is presented to the processor this cycle |
| instr_code | output | 4 | Instruction code, 1 to 10 |
| in_data | output | DW (8) | Value on the processor's input port |
| proc_out | input | DW (8) | Processor output port, one cycle after the instruction that writes it |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished |
| fail | output | 1 | The last run stopped on a mismatch |
| fail_index | output | IW (8) | Step index of the mismatch |

## Verification
The assertions assume that the processor executes each valid instruction at the clock edge that ends its cycle, so that `proc_out` reflects code 4 in the following cycle. The bench's processor model runs with exactly this one-cycle latency. The assertions also assume that `start` is a clean synchronous level. The bench raises `start` for a single cycle between falling edges, including once in the middle of a run, where it is paired with the opposite `mode_sel` value. Faults are injected only into the bench's processor model, as a wrong sum for one operand pair or as one instruction code executed as another. This keeps the sequencer's own stimulus within the template.

// File: rtl/tps_pkg.sv
package tps_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LDR,
        PH_LDA,
        PH_OP,
        PH_OBS,
        PH_CHK
    } phase_e;

    typedef enum logic {
        MODE_ADDER  = 1'b0,
        MODE_DECODE = 1'b1
    } mode_e;

    localparam logic [3:0] OP_A_IN   = 4'd1;
    localparam logic [3:0] OP_R_A    = 4'd2;
    localparam logic [3:0] OP_OUT_R  = 4'd3;
    localparam logic [3:0] OP_OUT_A  = 4'd4;
    localparam logic [3:0] OP_R_IN   = 4'd5;
    localparam logic [3:0] OP_A_IN2  = 4'd6;
    localparam logic [3:0] OP_ADD    = 4'd7;
    localparam logic [3:0] OP_OR     = 4'd8;
    localparam logic [3:0] OP_AND    = 4'd9;
    localparam logic [3:0] OP_NOT    = 4'd10;

    localparam logic [3:0] DEC_FIRST = 4'd1;
    localparam logic [3:0] DEC_LAST  = 4'd10;

endpackage

// File: rtl/tps_stim_gen.sv
module tps_stim_gen
    import tps_pkg::*;
#(
    parameter int             DW     = 8,
    parameter int             OPW    = 4,
    parameter int             IW     = 8,
    parameter logic [DW-1:0]  DEC_IN = 8'h5A,
    parameter logic [DW-1:0]  DEC_A  = 8'h0F,
    parameter logic [DW-1:0]  DEC_R  = 8'h33
) (
    input  phase_e          phase,
    input  mode_e           mode,
    input  logic [IW-1:0]   idx,
    output logic            valid,
    output logic [3:0]      code,
    output logic [DW-1:0]   din
);

    logic [DW-1:0] a_op;
    logic [DW-1:0] r_op;
    logic [3:0]    op_code;
    logic          is_add;

    assign is_add  = (mode == MODE_ADDER);
    assign a_op    = DW'(idx[2*OPW-1:OPW]);
    assign r_op    = DW'(idx[OPW-1:0]);
    assign op_code = is_add ? OP_ADD : idx[3:0];

    always_comb begin
        valid = 1'b0;
        code  = 4'd0;
        din   = '0;
        case (phase)
            PH_LDR: begin
                valid = 1'b1;
                code  = OP_R_IN;
                din   = is_add ? r_op : DEC_R;
            end
            PH_LDA: begin
                valid = 1'b1;
                code  = OP_A_IN;
                din   = is_add ? a_op : DEC_A;
            end
            PH_OP: begin
                valid = 1'b1;
                code  = op_code;
                din   = is_add ? '0 : DEC_IN;
            end
            PH_OBS: begin
                valid = 1'b1;
                code  = OP_OUT_A;
                din   = is_add ? '0 : DEC_IN;
            end
            default: begin
                valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tps_ref_model.sv
module tps_ref_model
    import tps_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic [3:0]    code,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] exp_out
);

    typedef struct packed {
        logic [DW-1:0] acc;
        logic [DW-1:0] rreg;
        logic [DW-1:0] outr;
    } regs_t;

    regs_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (valid) begin
            case (code)
                OP_A_IN, OP_A_IN2: m_d.acc  = din;
                OP_R_A:            m_d.rreg = m_q.acc;
                OP_OUT_R:          m_d.outr = m_q.rreg;
                OP_OUT_A:          m_d.outr = m_q.acc;
                OP_R_IN:           m_d.rreg = din;
                OP_ADD:            m_d.acc  = m_q.acc + m_q.rreg;
                OP_OR:             m_d.acc  = m_q.acc | m_q.rreg;
                OP_AND:            m_d.acc  = m_q.acc & m_q.rreg;
                OP_NOT:            m_d.acc  = ~m_q.acc;
                default:           m_d      = m_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign exp_out = m_q.outr;

    // R6: only the two output instructions may change the expected output
    a_r6_out_only_on_out_ops : assert property (@(posedge clk) disable iff (!rst_n)
        (!(valid && (code == OP_OUT_R || code == OP_OUT_A))) |=> $stable(exp_out));

endmodule

// File: rtl/func_test_seq.sv
module func_test_seq
    import tps_pkg::*;
#(
    parameter int            DW     = 8,
    parameter int            OPW    = 4,
    parameter logic [DW-1:0] DEC_IN = 8'h5A,
    parameter logic [DW-1:0] DEC_A  = 8'h0F,
    parameter logic [DW-1:0] DEC_R  = 8'h33,
    localparam int           IW     = (2*OPW > 4) ? 2*OPW : 4,
    localparam int           NPAIR  = 1 << (2*OPW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode_sel,
    output logic          instr_valid,
    output logic [3:0]    instr_code,
    output logic [DW-1:0] in_data,
    input  logic [DW-1:0] proc_out,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [IW-1:0] fail_index
);

    localparam logic [IW-1:0] ADD_LAST = IW'(NPAIR - 1);
    localparam logic [IW-1:0] DEC_END  = IW'(DEC_LAST);
    localparam logic [IW-1:0] DEC_BEG  = IW'(DEC_FIRST);

    typedef struct packed {
        phase_e        phase;
        mode_e         mode;
        logic [IW-1:0] idx;
        logic          done;
        logic          fail;
        logic [IW-1:0] fail_idx;
    } seq_t;

    seq_t st_d, st_q;

    logic [DW-1:0] exp_out;
    logic          last_step;
    logic          mismatch;

    tps_stim_gen #(
        .DW    (DW),
        .OPW   (OPW),
        .IW    (IW),
        .DEC_IN(DEC_IN),
        .DEC_A (DEC_A),
        .DEC_R (DEC_R)
    ) u_stim (
        .phase(st_q.phase),
        .mode (st_q.mode),
        .idx  (st_q.idx),
        .valid(instr_valid),
        .code (instr_code),
        .din  (in_data)
    );

    tps_ref_model #(
        .DW(DW)
    ) u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (instr_valid),
        .code   (instr_code),
        .din    (in_data),
        .exp_out(exp_out)
    );

    assign last_step = (st_q.mode == MODE_ADDER) ? (st_q.idx == ADD_LAST)
                                                 : (st_q.idx == DEC_END);
    assign mismatch  = (proc_out != exp_out);

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.mode     = mode_e'(mode_sel);
                    st_d.idx      = (mode_sel == 1'b1) ? DEC_BEG : '0;
                    st_d.phase    = PH_LDR;
                    st_d.done     = 1'b0;
                    st_d.fail     = 1'b0;
                    st_d.fail_idx = '0;
                end
            end
            PH_LDR: st_d.phase = PH_LDA;
            PH_LDA: st_d.phase = PH_OP;
            PH_OP:  st_d.phase = PH_OBS;
            PH_OBS: st_d.phase = PH_CHK;
            PH_CHK: begin
                if (mismatch) begin
                    st_d.fail     = 1'b1;
                    st_d.fail_idx = st_q.idx;
                    st_d.done     = 1'b1;
                    st_d.phase    = PH_IDLE;
                end else if (last_step) begin
                    st_d.done  = 1'b1;
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.idx   = st_q.idx + 1'b1;
                    st_d.phase = PH_LDR;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, mode: MODE_ADDER, idx: '0,
                      done: 1'b0, fail: 1'b0, fail_idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy       = (st_q.phase != PH_IDLE);
    assign done       = st_q.done;
    assign fail       = st_q.fail;
    assign fail_index = st_q.fail_idx;

    // R3: the R load is always followed by the A load
    a_r3_ldr_then_lda : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_LDR) |=> (instr_valid && instr_code == OP_R_IN ? 1'b0 : instr_valid && instr_code == OP_A_IN));

    // R3: observation phase presents the output instruction
    a_r3_obs_code : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_OBS) |-> (instr_valid && instr_code == OP_OUT_A));

    // R3: compare cycle issues nothing
    a_r3_chk_gap : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_CHK) |-> !instr_valid);

    // R2: the mode is not changed by start during a run
    a_r2_mode_held : assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(st_q.mode));

    // R7: a failure is always reported together with done
    a_r7_fail_with_done : assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (done && !busy));

    // R8: results hold while idle without start
    a_r8_result_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (done && !busy && !start) |=> (done && $stable(fail) && $stable(fail_index)));

endmodule

// File: tb/tb_func_test_seq.sv
`timescale 1ns/1ps
module tb_func_test_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       mode_sel = 1'b0;
    logic       instr_valid;
    logic [3:0] instr_code;
    logic [7:0] in_data;
    logic [7:0] proc_out;
    logic       busy, done, fail;
    logic [7:0] fail_index;

    int checks = 0;
    int fails  = 0;

    // fault controls for the processor model
    int         flt_kind = 0;      // 0 none, 1 wrong sum, 2 code swap
    logic [7:0] flt_a = 0, flt_r = 0;
    logic [3:0] swap_from = 0, swap_to = 0;

    always #2 clk = ~clk;

    func_test_seq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode_sel   (mode_sel),
        .instr_valid(instr_valid),
        .instr_code (instr_code),
        .in_data    (in_data),
        .proc_out   (proc_out),
        .busy       (busy),
        .done       (done),
        .fail       (fail),
        .fail_index (fail_index)
    );

    // processor under test, one-cycle latency
    logic [7:0] pa, pr, po;
    logic [3:0] pc;
    assign proc_out = po;

    always @(posedge clk) begin
        if (!rst_n) begin
            pa <= 0; pr <= 0; po <= 0;
        end else if (instr_valid) begin
            pc = instr_code;
            if (flt_kind == 2 && pc == swap_from) pc = swap_to;
            case (pc)
                4'd1, 4'd6: pa <= in_data;
                4'd2:       pr <= pa;
                4'd3:       po <= pr;
                4'd4:       po <= pa;
                4'd5:       pr <= in_data;
                4'd7:       pa <= pa + pr + ((flt_kind == 1 && pa == flt_a && pr == flt_r) ? 8'd1 : 8'd0);
                4'd8:       pa <= pa | pr;
                4'd9:       pa <= pa & pr;
                4'd10:      pa <= ~pa;
                default:    ;
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic void exp_beat(input bit m, input int beat,
                                     output logic [3:0] c, output logic [7:0] d);
        int s = beat / 4;
        int ph = beat % 4;
        if (!m) begin
            logic [7:0] a = 8'((s >> 4) & 15);
            logic [7:0] r = 8'(s & 15);
            case (ph)
                0: begin c = 4'd5; d = r; end
                1: begin c = 4'd1; d = a; end
                2: begin c = 4'd7; d = 8'h00; end
                default: begin c = 4'd4; d = 8'h00; end
            endcase
        end else begin
            case (ph)
                0: begin c = 4'd5; d = 8'h33; end
                1: begin c = 4'd1; d = 8'h0F; end
                2: begin c = 4'(s + 1); d = 8'h5A; end
                default: begin c = 4'd4; d = 8'h5A; end
            endcase
        end
    endfunction

    // one complete run; checks sequence, count and result
    task automatic run(input bit m, input bit poke, input bit exp_fail,
                       input int exp_idx, input int exp_beats, input string tag);
        int beats = 0;
        int seqerr = 0;
        int cyc = 0;
        bit prev_obs = 0;
        bit fin = 0;
        logic [3:0] ec;
        logic [7:0] ed;
        @(negedge clk);
        mode_sel = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done && !fail, {tag, " R2 launch"}, {busy, done, fail}, 3'b100);
        while (!fin && cyc < 3000) begin
            if (prev_obs && instr_valid) seqerr++;
            prev_obs = 0;
            start = 1'b0;
            mode_sel = m;
            if (instr_valid) begin
                exp_beat(m, beats, ec, ed);
                if (instr_code != ec || in_data != ed) seqerr++;
                if (beats % 4 == 3) prev_obs = 1;
                beats++;
                if (poke && beats == 6) begin
                    start = 1'b1;
                    mode_sel = ~m;
                end
            end
            if (done) fin = 1;
            else begin
                @(negedge clk);
                cyc++;
            end
        end
        start = 1'b0;
        mode_sel = m;
        chk(fin, {tag, " watchdog"}, fin, 1);
        chk(seqerr == 0, {tag, " R3 R4 R5 program sequence"}, seqerr, 0);
        chk(beats == exp_beats, {tag, " R3 instruction count"}, beats, exp_beats);
        chk(fail == exp_fail, {tag, " R7 R8 fail flag"}, fail, exp_fail);
        if (exp_fail)
            chk(fail_index == 8'(exp_idx), {tag, " R7 fail index"}, fail_index, exp_idx);
        repeat (3) @(negedge clk);
        chk(done && !busy && !instr_valid && fail == exp_fail,
            {tag, " R8 result held, R7 halted"}, {done, busy, instr_valid, fail}, {3'b100, exp_fail});
    endtask

    task automatic t_reset();
        chk(!busy && !done && !fail && !instr_valid, "R1 reset state",
            {busy, done, fail, instr_valid}, 0);
    endtask

    task automatic t_adder_pass();
        flt_kind = 0;
        run(1'b0, 1'b0, 1'b0, 0, 1024, "adder pass R6");
    endtask

    task automatic t_adder_fault(input int a, input int r);
        flt_kind = 1; flt_a = 8'(a); flt_r = 8'(r);
        run(1'b0, 1'b0, 1'b1, a * 16 + r, (a * 16 + r + 1) * 4, "adder fault R7");
        flt_kind = 0;
    endtask

    task automatic t_decode_pass();
        flt_kind = 0;
        run(1'b1, 1'b0, 1'b0, 0, 40, "decode pass R5 R9");
    endtask

    task automatic t_decode_swap(input int from, input int to);
        flt_kind = 2; swap_from = 4'(from); swap_to = 4'(to);
        run(1'b1, 1'b0, 1'b1, from, from * 4, "decode fault R7");
        flt_kind = 0;
    endtask

    task automatic t_ignore_start();
        flt_kind = 0;
        run(1'b1, 1'b1, 1'b0, 0, 40, "start during run R2");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_adder_pass();
        t_adder_fault(9, 6);
        t_adder_fault(0, 0);
        t_adder_fault(15, 15);
        t_decode_swap(8, 9);
        t_decode_pass();
        t_decode_swap(10, 0);
        t_decode_swap(1, 0);
        t_ignore_start();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule